// File: doc/BRIEF.md
# Serial Receive Buffer with Per-Character Status

This block is the buffering stage behind a serial receiver's shift register. Each time the shift register finishes a frame, the block stores the character in a small circular queue. The character's ninth data bit and its framing-error flag are stored in the same entry. A host reads the status of the oldest character, then reads the data, which removes that entry. The status therefore always belongs to the character that is about to be read.

When both queue entries are occupied, a newly finished character is not dropped. It waits in a holding stage that stands for the shift register and acts as a third storage level. The held character moves into the queue on the clock after a slot becomes free. A character is lost only when the queue is full, the holding stage is occupied, and a new start bit is detected. In that case the held character is discarded and an overrun flag is set on the newest character in the queue, which is the one that came just before the lost one.

Top module: `uart_rxbuf`

## Requirements
- R1: After a synchronous active-low reset, `rx_ready` is 0, `rd_q` is 0 and `stat_q` is 0.
- R2: Characters are delivered to the host in the order their frames completed. The queue holds at most DEPTH entries.
- R3: A `data_rd` pulse while the queue is non-empty removes the oldest entry, and its data appears on `rd_q` one cycle later.
- R4: A `stat_rd` pulse loads `stat_q` one cycle later with the oldest entry's flags, encoded as bit 2 = ninth data bit, bit 1 = framing error, bit 0 = overrun. If the queue is empty, it loads 0.
- R5: A frame that completes while the queue is full is kept in the holding stage and is delivered later. It is not dropped.
- R6: When a slot becomes free while a character is held, that character enters the queue on the next clock. It is then read back after the older entries.
- R7: `rx_ready` is 1 exactly when the queue holds at least one entry.
- R8: A `data_rd` pulse while the queue is empty leaves `rd_q` unchanged and does not alter the queue contents.
- R9: `start_det` while the queue is full and a character is held discards the held character and sets the overrun flag of the newest queue entry.
- R10: The overrun flag belongs to a single entry only. Once that entry is removed, the next entry reports its own flag, which is 0 unless a later overrun set it.
- R11: The ninth data bit and the framing-error flag of each frame stay with that character and are reported when it reaches the head of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | Frame-complete strobe from the shift register |
| frame_data | input | DATA_W | Received character |
| frame_bit9 | input | 1 | Ninth data bit of the frame |
| frame_ferr | input | 1 | Framing error of the frame |
| start_det | input | 1 | Start bit of a new frame detected |
| data_rd | input | 1 | Host data read strobe (pops the head entry) |
| stat_rd | input | 1 | Host status read strobe |
| rx_ready | output | 1 | Queue holds at least one character |
| rd_q | output | DATA_W | Last character read by the host |
| stat_q | output | 3 | Head flags captured by the last status read |

## Verification
The bench uses the default build, DATA_W = 8 and DEPTH = 2. With a depth this shallow, the queue reaches full within two frames. A third frame then exercises the holding stage, and a start strobe right after it produces an overrun. Freeing a slot shows the held character moving into the queue. Because every corner is this close, a long stream of random strobes visits full-plus-held, overrun followed by a pop, and empty reads many times. A behavioural queue model checks each of these cases on every clock.

// File: rtl/rxb_pkg.sv
// Shared types for the serial receive buffer.
package rxb_pkg;
    // Per-character status carried through the queue
    typedef struct packed {
        logic bit9;
        logic ferr;
        logic dor;
    } rxb_flags_t;

    localparam int FLAGS_W = $bits(rxb_flags_t);
endpackage

// File: rtl/rxb_fifo.sv
// Circular character queue of DEPTH entries. Each entry holds the data and its flags.
// Assumes: wr_en only when not full, pop only when not empty, and mark_dor only when
// full. These are guaranteed by the parent.
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  rxb_flags_t        wr_flags,
    input  logic              pop,
    input  logic              mark_dor,
    output logic [DATA_W-1:0] head_data,
    output rxb_flags_t        head_flags,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] data_mem [DEPTH];
    rxb_flags_t        flag_mem [DEPTH];
    logic [PW-1:0]     rd_ptr, wr_ptr, newest_ptr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Index of the most recently written entry
    always_comb newest_ptr = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;

    // Storage entries: write a new character, or set the overrun flag of the newest one
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_mem[gi] <= '0;
                flag_mem[gi] <= '0;
            end else if (wr_en && wr_ptr == PW'(gi)) begin
                data_mem[gi] <= wr_data;
                flag_mem[gi] <= wr_flags;
            end else if (mark_dor && newest_ptr == PW'(gi)) begin
                flag_mem[gi].dor <= 1'b1;
            end
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)   rd_ptr <= ptr_inc(rd_ptr);
            case ({wr_en, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head of queue seen by the host
    always_comb begin
        head_data  = data_mem[rd_ptr];
        head_flags = flag_mem[rd_ptr];
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R2
    wr_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> count < FULL_CNT);
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
    // R9
    dor_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dor |-> count == FULL_CNT);
endmodule

// File: rtl/rxb_hold.sv
// Holding stage that stands for the receive shift register. It admits characters
// into the queue, keeps one character while the queue is full, and declares
// overrun. Assumes frame_valid and start_det are not both asserted in one cycle.
module rxb_hold
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  rxb_flags_t        frame_flags,
    input  logic              start_det,
    input  logic              has_space,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output rxb_flags_t        wr_flags,
    output logic              overrun
);
    logic              held;
    logic [DATA_W-1:0] held_data;
    rxb_flags_t        held_flags;
    logic              move, direct;

    // Admission: a held character has priority over a new frame
    always_comb begin
        move     = held && has_space;
        direct   = frame_valid && !held && has_space;
        wr_en    = move || direct;
        wr_data  = move ? held_data  : frame_data;
        wr_flags = move ? held_flags : frame_flags;
        overrun  = start_det && held && !has_space;
    end

    // Holding register: capture frames that cannot enter, release on move or overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= 1'b0;
            held_data  <= '0;
            held_flags <= '0;
        end else if (frame_valid && !direct) begin
            held       <= 1'b1;
            held_data  <= frame_data;
            held_flags <= frame_flags;
        end else if (move || overrun) begin
            held <= 1'b0;
        end
    end

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && !has_space |=> held);
    // R6
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && has_space && !frame_valid |=> !held);
    // R9
    ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !frame_valid |=> !held);
endmodule

// File: rtl/rxb_host.sv
// Host read registers: the data register is loaded on a pop, and the status
// register is loaded from the head entry on a status read.
// Assumes pop is already gated with "queue not empty".
module rxb_host
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              stat_rd,
    input  logic              not_empty,
    input  logic [DATA_W-1:0] head_data,
    input  rxb_flags_t        head_flags,
    output logic [DATA_W-1:0] rd_q,
    output logic [FLAGS_W-1:0] stat_q
);
    // Data register: takes the head character when it is popped
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_q <= '0;
        else if (pop) rd_q <= head_data;
    end

    // Status register: snapshot of the head flags, zero when empty
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (stat_rd) stat_q <= not_empty ? head_flags : '0;
    end

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(rd_q));
    // R4
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> $stable(stat_q));
endmodule

// File: rtl/uart_rxbuf.sv
// Receive buffer top: a queue of DEPTH entries, a holding stage, and host read
// registers. Serial sampling and baud timing are handled upstream.
module uart_rxbuf
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_bit9,
    input  logic              frame_ferr,
    input  logic              start_det,
    input  logic              data_rd,
    input  logic              stat_rd,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rd_q,
    output logic [2:0]        stat_q
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]     count;
    logic              has_space, pop, wr_en, overrun;
    logic [DATA_W-1:0] wr_data, head_data;
    rxb_flags_t        wr_flags, head_flags, in_flags;

    // Glue: incoming flags, pop gating, occupancy view
    always_comb begin
        in_flags  = '{bit9: frame_bit9, ferr: frame_ferr, dor: 1'b0};
        has_space = count < CW'(DEPTH);
        rx_ready  = count != '0;
        pop       = data_rd && rx_ready;
    end

    rxb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_flags(in_flags), .start_det(start_det), .has_space(has_space),
        .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags), .overrun(overrun)
    );

    rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags),
        .pop(pop), .mark_dor(overrun), .head_data(head_data), .head_flags(head_flags),
        .count(count)
    );

    rxb_host #(.DATA_W(DATA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .pop(pop), .stat_rd(stat_rd), .not_empty(rx_ready),
        .head_data(head_data), .head_flags(head_flags), .rd_q(rd_q), .stat_q(stat_q)
    );

    // R7
    ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !pop |=> rx_ready);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> !rx_ready && rd_q == '0 && stat_q == '0);
endmodule

// File: tb/uart_rxbuf_tb.sv
module uart_rxbuf_tb;
    localparam int DW = 8;
    localparam int DEPTH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 0, frame_bit9 = 0, frame_ferr = 0, start_det = 0;
    logic data_rd = 0, stat_rd = 0;
    logic [DW-1:0] frame_data = '0;
    logic rx_ready;
    logic [DW-1:0] rd_q;
    logic [2:0] stat_q;

    int total = 0, bad = 0, cycles = 0;
    string tag = "R1";

    // Model: entry = {data, bit9, ferr, dor}
    logic [DW+2:0] q[$];
    logic [DW+2:0] m_hold;
    logic m_held = 0;
    logic [DW-1:0] e_rdq = '0;
    logic [2:0] e_stat = '0;

    always #2 clk = ~clk;

    uart_rxbuf #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_bit9(frame_bit9), .frame_ferr(frame_ferr), .start_det(start_det),
        .data_rd(data_rd), .stat_rd(stat_rd), .rx_ready(rx_ready), .rd_q(rd_q),
        .stat_q(stat_q)
    );

    // Behavioural reference, evaluated on the pre-edge state
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete(); m_held = 0; e_rdq = '0; e_stat = '0;
        end else begin
            int sz;
            logic hv, full, mv, dir, ovr;
            logic [DW+2:0] fr, t;
            sz = q.size(); hv = m_held; full = (sz >= DEPTH);
            fr = {frame_data, frame_bit9, frame_ferr, 1'b0};
            ovr = start_det && hv && full;
            mv = hv && !full;
            dir = frame_valid && !hv && !full;
            if (stat_rd) e_stat = (sz > 0) ? q[0][2:0] : 3'b000;
            if (ovr) begin
                t = q[sz-1]; t[0] = 1'b1; q[sz-1] = t; m_held = 0;
            end
            if (data_rd && sz > 0) begin
                e_rdq = q[0][DW+2:3]; void'(q.pop_front());
            end
            if (mv) begin q.push_back(m_hold); m_held = 0; end
            if (dir) q.push_back(fr);
            else if (frame_valid) begin m_hold = fr; m_held = 1; end
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(rx_ready == (q.size() != 0), "rx_ready(R7)", int'(rx_ready), int'(q.size() != 0));
        chk(rd_q == e_rdq, "rd_q(R3)", int'(rd_q), int'(e_rdq));
        chk(stat_q == e_stat, "stat_q(R4)", int'(stat_q), int'(e_stat));
    endtask

    // One clock: drive after negedge, compare at the next negedge
    task automatic cyc(input logic fv, input logic [DW-1:0] fd, input logic b9, input logic fe,
                       input logic st, input logic rd, input logic sr);
        frame_valid = fv; frame_data = fd; frame_bit9 = b9; frame_ferr = fe;
        start_det = st; data_rd = rd; stat_rd = sr;
        @(negedge clk);
        frame_valid = 0; start_det = 0; data_rd = 0; stat_rd = 0;
        compare();
    endtask

    task automatic idle(); cyc(0, '0, 0, 0, 0, 0, 0); endtask

    initial begin
        @(negedge clk); @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        idle();

        tag = "R2 R11";                      // two frames, different flags
        cyc(1, 8'hA1, 1, 0, 0, 0, 0);
        cyc(1, 8'hB2, 0, 1, 0, 0, 0);
        tag = "R5";                          // third frame goes to hold
        cyc(1, 8'hC3, 1, 1, 0, 0, 0);
        idle();
        tag = "R4 R11";
        cyc(0, '0, 0, 0, 0, 0, 1);           // status of A1 -> 3'b100
        chk(stat_q == 3'b100, "R11 stat A1", int'(stat_q), 4);
        tag = "R6";
        cyc(0, '0, 0, 0, 0, 1, 0);           // pop A1, C3 moves next clock
        idle();
        tag = "R9";                          // full + held: load D4 then start
        cyc(1, 8'hD4, 0, 0, 0, 0, 0);        // D4 held
        cyc(0, '0, 0, 0, 1, 0, 0);           // overrun: D4 lost, C3 gets dor
        tag = "R2 R10";
        cyc(0, '0, 0, 0, 0, 0, 1);           // status of B2 -> 010
        chk(stat_q == 3'b010, "R10 stat B2", int'(stat_q), 2);
        cyc(0, '0, 0, 0, 0, 1, 0);
        chk(rd_q == 8'hB2, "R2 rd B2", int'(rd_q), 'hB2);
        cyc(0, '0, 0, 0, 0, 0, 1);           // status of C3 -> 111
        chk(stat_q == 3'b111, "R9 stat C3", int'(stat_q), 7);
        cyc(0, '0, 0, 0, 0, 1, 0);
        chk(rd_q == 8'hC3, "R6 rd C3", int'(rd_q), 'hC3);
        tag = "R8";
        cyc(0, '0, 0, 0, 0, 1, 0);           // empty read
        chk(rd_q == 8'hC3 && !rx_ready, "R8 empty rd", int'(rd_q), 'hC3);
        cyc(0, '0, 0, 0, 0, 0, 1);
        chk(stat_q == 3'b000, "R4 empty stat", int'(stat_q), 0);
        tag = "R10";
        cyc(1, 8'h5E, 0, 0, 0, 0, 0);
        cyc(0, '0, 0, 0, 0, 0, 1);
        chk(stat_q == 3'b000, "R10 fresh dor", int'(stat_q), 0);
        cyc(0, '0, 0, 0, 0, 1, 0);

        tag = "R2 R3 R4 R5 R6 R7 R9";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 10);
            cyc(r == 1 || r == 2, DW'($urandom), 1'($urandom), 1'($urandom), r == 0,
                ($urandom % 3) == 0, ($urandom % 3) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule